// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block keeps a 17-bit word of pending software interrupts and a 4-bit processor interrupt level beside it. From these two registers it derives one interrupt request line per pending bit. Bits 1 through 15 are ordinary software levels. Bit 0 and bit 16 are the two timer-match flags: the tick comparator sets bit 0 and the system-tick comparator sets bit 16.

Software updates the block through one write port with a 2-bit address. Address 0 replaces the whole word. Address 1 ORs the data into the word, and address 2 clears every bit that is 1 in the data. Address 3 loads the interrupt level from data bits [3:0]. A 1-bit select returns either the pending word or the level on the read-back port. Trap vectoring and arbitration between the request lines are left to the logic downstream.

The request vector is built combinationally from the two registers, so every change appears in the cycle after the edge that caused it.

Top module: `swi_soft_irq`

## Requirements
- R1: After reset the pending word is 0, the level is 0 and all 17 request lines are low.
- R2: A write with address 0 replaces the pending word with the 17 data bits.
- R3: A write with address 1 makes the pending word equal to its old value OR the data.
- R4: A write with address 2 makes the pending word equal to its old value AND NOT the data.
- R5: For each n from 1 to 15, request n is high exactly when pending bit n is set and n is strictly greater than the level.
- R6: Requests 0 and 16 are high exactly when their pending bit is set and the level is below 14. Their bit index plays no part.
- R7: A write with address 3 loads the level from data[3:0] and leaves the pending word unchanged. All request lines are then re-evaluated against the new level.
- R8: tick_hit sets pending bit 0 and stick_hit sets pending bit 16. If a write with address 0 or 2 would clear the same bit in the same cycle, the event wins and the bit ends set.
- R9: Request lines keep their old value until the clock edge that captures a write or an event. They show the new state from that edge onward.
- R10: With rd_sel at 0, rd_data returns the pending word. With rd_sel at 1, rd_data returns the level zero-extended to 17 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 load, 1 set, 2 clear, 3 level |
| wr_data | input | 17 | Write data |
| tick_hit | input | 1 | Tick comparator match, sets bit 0 |
| stick_hit | input | 1 | System-tick comparator match, sets bit 16 |
| rd_sel | input | 1 | 0 returns pending word, 1 returns level |
| rd_data | output | 17 | Read-back value |
| irq_req | output | 17 | Per-bit interrupt requests |

## Verification
A timer-match event and a register write that clears the same flag can arrive in the same cycle. The bench provokes this three ways: a clear write to address 2 with tick_hit, the same write with stick_hit, and a load of zero to address 0 with stick_hit. The scoreboard expects the struck bit to stay set and the other flag to follow the write. The same check is made on the request line for that bit.

// File: rtl/swi_pkg.sv
package swi_pkg;

    // Write port address map
    typedef enum logic [1:0] {
        ADDR_LOAD  = 2'd0,
        ADDR_SET   = 2'd1,
        ADDR_CLEAR = 2'd2,
        ADDR_LEVEL = 2'd3
    } swi_addr_e;

    // Decoded action for one cycle
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_SET,
        ACT_CLEAR,
        ACT_LEVEL
    } swi_act_e;

endpackage

// File: rtl/swi_decode.sv
module swi_decode
    import swi_pkg::*;
(
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    output swi_act_e   act
);

    always_comb begin
        act = ACT_IDLE;
        if (wr_en) begin
            unique case (swi_addr_e'(wr_addr))
                ADDR_LOAD:  act = ACT_LOAD;
                ADDR_SET:   act = ACT_SET;
                ADDR_CLEAR: act = ACT_CLEAR;
                ADDR_LEVEL: act = ACT_LEVEL;
            endcase
        end
    end

endmodule

// File: rtl/swi_pending.sv
module swi_pending
    import swi_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  swi_act_e     act,
    input  logic [W-1:0] wr_data,
    input  logic         tick_hit,
    input  logic         stick_hit,
    output logic [W-1:0] pend_q
);

    localparam int HI = W - 1;

    logic [W-1:0] written;
    logic [W-1:0] events;
    logic [W-1:0] pend_d;

    // Effect of the write alone
    always_comb begin
        unique case (act)
            ACT_LOAD:  written = wr_data;
            ACT_SET:   written = pend_q | wr_data;
            ACT_CLEAR: written = pend_q & ~wr_data;
            default:   written = pend_q;
        endcase
    end

    // Timer events are applied last, so they win over a same-cycle clear
    always_comb begin
        events     = '0;
        events[0]  = tick_hit;
        events[HI] = stick_hit;
        pend_d     = written | events;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/swi_level.sv
module swi_level
    import swi_pkg::*;
#(
    parameter int PIL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  swi_act_e         act,
    input  logic [PIL_W-1:0] lvl_data,
    output logic [PIL_W-1:0] pil_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)                 pil_q <= '0;
        else if (act == ACT_LEVEL)  pil_q <= lvl_data;
    end

endmodule

// File: rtl/swi_mask.sv
module swi_mask #(
    parameter int W          = 17,
    parameter int PIL_W      = 4,
    parameter int TIMER_GATE = 14
) (
    input  logic [W-1:0]     pend,
    input  logic [PIL_W-1:0] pil,
    output logic [W-1:0]     req
);

    localparam int                 CW     = PIL_W + 1;
    localparam logic [CW-1:0]      GATE_V = CW'(TIMER_GATE);

    logic [CW-1:0] pil_x;
    assign pil_x = {1'b0, pil};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0 || i == W - 1) begin : g_timer
            // Timer flags use a fixed threshold instead of the bit index
            assign req[i] = pend[i] && (pil_x < GATE_V);
        end else begin : g_level
            localparam logic [CW-1:0] IDX = CW'(i);
            assign req[i] = pend[i] && (IDX > pil_x);
        end
    end

endmodule

// File: rtl/swi_soft_irq.sv
module swi_soft_irq
    import swi_pkg::*;
#(
    parameter int W          = 17,
    parameter int PIL_W      = 4,
    parameter int TIMER_GATE = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tick_hit,
    input  logic         stick_hit,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] irq_req
);

    swi_act_e         act;
    logic [W-1:0]     pend_q;
    logic [PIL_W-1:0] pil_q;

    swi_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .act     (act)
    );

    swi_pending #(.W(W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .wr_data   (wr_data),
        .tick_hit  (tick_hit),
        .stick_hit (stick_hit),
        .pend_q    (pend_q)
    );

    swi_level #(.PIL_W(PIL_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .lvl_data (wr_data[PIL_W-1:0]),
        .pil_q    (pil_q)
    );

    swi_mask #(.W(W), .PIL_W(PIL_W), .TIMER_GATE(TIMER_GATE)) u_mask (
        .pend (pend_q),
        .pil  (pil_q),
        .req  (irq_req)
    );

    assign rd_data = rd_sel ? W'(pil_q) : pend_q;

endmodule

// File: rtl/swi_checker.sv
module swi_checker #(
    parameter int W          = 17,
    parameter int PIL_W      = 4,
    parameter int TIMER_GATE = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [W-1:0]     wr_data,
    input logic             tick_hit,
    input logic             stick_hit,
    input logic [W-1:0]     pend_q,
    input logic [PIL_W-1:0] pil_q,
    input logic [W-1:0]     irq_req
);

    localparam int                 HI     = W - 1;
    localparam logic [PIL_W:0]     GATE_V = (PIL_W + 1)'(TIMER_GATE);

    // R3: set alias leaves every written bit set
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> ((pend_q & $past(wr_data)) == $past(wr_data)));

    // R4: clear alias leaves every written bit clear when no event is present
    a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && !tick_hit && !stick_hit) |=> ((pend_q & $past(wr_data)) == '0));

    // R5: no request without a pending bit behind it
    a_r5_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~pend_q) == '0));

    // R6: timer flag requests are held off at or above the threshold
    a_r6_timer_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pil_q} >= GATE_V) |-> (!irq_req[0] && !irq_req[HI]));

    // R7: a level write does not disturb the pending word
    a_r7_level_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !tick_hit && !stick_hit) |=> $stable(pend_q));

    // R8: tick event always lands
    a_r8_tick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tick_hit |=> pend_q[0]);

    // R8: system-tick event always lands
    a_r8_stick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stick_hit |=> pend_q[HI]);

    // R9: with no write and no event, requests hold
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_hit && !stick_hit) |=> $stable(irq_req));

endmodule

bind swi_soft_irq swi_checker #(
    .W(W), .PIL_W(PIL_W), .TIMER_GATE(TIMER_GATE)
) u_swi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick_hit  (tick_hit),
    .stick_hit (stick_hit),
    .pend_q    (pend_q),
    .pil_q     (pil_q),
    .irq_req   (irq_req)
);

// File: tb/swi_soft_irq_bench.sv
`timescale 1ns/1ps
module swi_soft_irq_bench;

    localparam int W = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         tick_hit = 1'b0;
    logic         stick_hit = 1'b0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic [W-1:0] irq_req;

    always #2 clk = ~clk;   // 250 MHz

    swi_soft_irq u_swi_soft_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_hit(tick_hit), .stick_hit(stick_hit),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_req(irq_req)
    );

    typedef struct {
        logic [W-1:0] word;
        logic [W-1:0] req;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 0;
    logic [W-1:0] m_word = '0;
    logic [3:0]   m_pil = '0;

    function automatic logic [W-1:0] model_req(logic [W-1:0] w, logic [3:0] p);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            if (i == 0 || i == W - 1) r[i] = w[i] && (p < 4'd14);
            else                       r[i] = w[i] && (i > int'(p));
        end
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, then pushes the expected state
    task automatic apply(bit en, logic [1:0] addr, logic [W-1:0] data,
                         bit tk, bit stk, string tag);
        exp_t e;
        @(negedge clk);
        wr_en = en; wr_addr = addr; wr_data = data;
        tick_hit = tk; stick_hit = stk;
        #1;
        check({"R9 hold before edge ", tag}, irq_req, model_req(m_word, m_pil));
        if (en) begin
            case (addr)
                2'd0: m_word = data;
                2'd1: m_word = m_word | data;
                2'd2: m_word = m_word & ~data;
                default: m_pil = data[3:0];
            endcase
        end
        if (tk)  m_word[0]   = 1'b1;
        if (stk) m_word[W-1] = 1'b1;
        @(posedge clk);
        e.word = m_word;
        e.req  = model_req(m_word, m_pil);
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0; tick_hit = 1'b0; stick_hit = 1'b0;
    endtask

    task automatic check_level(string tag);
        @(negedge clk);
        rd_sel = 1'b1;
        #1;
        check({"R10 level readback ", tag}, rd_data, W'(m_pil));
        rd_sel = 1'b0;
    endtask

    // Monitor: pops expected items and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " word"}, rd_data, e.word);
                check({e.tag, " req"},  irq_req, e.req);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset word", rd_data, '0);
        check("R1 reset req", irq_req, '0);
        check_level("R1 reset");

        apply(1, 2'd0, 17'h1FFFF, 0, 0, "R2 load all, R5 R6 level 0");
        apply(1, 2'd3, 17'h00005, 0, 0, "R7 level 5");
        check_level("R7 level 5");
        apply(1, 2'd3, 17'h0000D, 0, 0, "R6 level 13");
        apply(1, 2'd3, 17'h0000E, 0, 0, "R6 level 14");
        apply(1, 2'd3, 17'h0000F, 0, 0, "R5 level 15");
        check_level("R7 level 15");
        apply(1, 2'd2, 17'h0F0F0, 0, 0, "R4 clear alias");
        apply(1, 2'd3, 17'h00000, 0, 0, "R7 level 0");
        apply(1, 2'd1, 17'h000F0, 0, 0, "R3 set alias");
        apply(1, 2'd2, 17'h10001, 1, 0, "R8 tick beats clear");
        apply(1, 2'd2, 17'h10001, 0, 1, "R8 stick beats clear");
        apply(0, 2'd0, 17'h00000, 1, 0, "R8 tick alone");
        apply(1, 2'd0, 17'h00000, 0, 1, "R8 stick beats load");
        apply(1, 2'd3, 17'h00003, 0, 0, "R7 level 3");
        apply(1, 2'd0, 17'h0000E, 0, 0, "R5 bits at or below level");
        apply(1, 2'd1, 17'h00010, 0, 0, "R5 bit just above level");
        apply(0, 2'd0, 17'h00000, 0, 0, "R9 idle hold");

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule